// File: doc/BRIEF.md
# Eight-Stage Pipeline Hazard Controller

This block is the interlock and control-flow unit of an in-order pipeline with eight stages: two instruction-fetch stages (IF, IS), decode and register read (RF), execute (EX), two data-access stages (DF, DS), a tag stage (TC) and writeback (WB). The front end presents the instruction sitting in RF: a valid flag, an operation class, two source register indices and a destination index. The controller keeps its own record of every instruction from EX to WB. From those records it decides whether RF must wait for load data, whether a bubble goes into EX, which front-end stages must be cancelled, where the next fetch address comes from, and which later stage each RF operand should be forwarded from.

Data cache results exist only at the end of DS. An instruction that reads a register just loaded by the instruction ahead of it, or by the one two ahead, must therefore wait in RF. Branches resolve in EX. At that point their single delay slot is in RF, and the two younger fetches in IS and IF are discarded when the branch is taken. A branch-likely instruction that is not taken cancels its delay slot, which enters EX as a bubble with no write enable.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: After a synchronous active-high reset, with no valid instruction in RF, `front_hold`, `ex_bubble`, `kill_front`, `kill_rf` and `wb_we` are 0, `wb_dst` is 0 and `pc_sel` is 0 (sequential).
- R2: When a valid RF instruction has a nonzero source index equal to the destination of a load in EX or DF, and the slot is not being annulled, `front_hold` and `ex_bubble` are 1 and `pc_sel` is not 0. The RF instruction does not enter EX in that cycle.
- R3: A consumer presented directly behind a load is held exactly 2 cycles. A consumer presented two behind the load is held exactly 1 cycle. Register index 0 never creates a dependence.
- R4: `fwd_a`/`fwd_b` name the nearest older writer of the matching nonzero source: 1 when it is in EX (read from DF next cycle), 2 in DF, 3 in DS, 4 in TC, and 0 when there is none. A writer in WB, or an ALU result directly ahead, causes no hold.
- R5: A consumer released after a load-use hold gets forward code 3, because the load data is taken from the end of DS.
- R6: When a branch or branch-likely instruction (class 4 or 5) in EX has `ex_taken` high, `kill_front` is 1 and `pc_sel` is 2 (target). The delay slot in RF is not killed.
- R7: When a branch-likely instruction in EX is not taken and RF holds a valid instruction, `kill_rf` and `ex_bubble` are 1 and `front_hold` is 0. The cancelled slot never produces `wb_we`.
- R8: An ordinary branch (class 4) that is not taken kills nothing, and its delay slot proceeds normally.
- R9: An ALU (class 1) or load (class 2) instruction that leaves RF in a cycle shows `wb_we`=1 with its destination on `wb_dst` during the fifth following cycle. No-ops (0), stores (3) and branches (4, 5) never assert `wb_we`. `wb_dst` is 0 whenever `wb_we` is 0.
- R10: `pc_sel` encodes 0 sequential, 1 hold, 2 target. Target wins over hold when a taken branch and a load-use hold occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_valid | input | 1 | RF holds a real instruction |
| rf_cls | input | 3 | Class of the RF instruction (0 nop, 1 ALU, 2 load, 3 store, 4 branch, 5 branch-likely) |
| rf_src_a | input | 5 | First source register index |
| rf_src_b | input | 5 | Second source register index |
| rf_dst | input | 5 | Destination register index |
| ex_taken | input | 1 | Branch outcome of the instruction in EX |
| front_hold | output | 1 | Hold IF, IS and RF this cycle |
| ex_bubble | output | 1 | A bubble enters EX instead of the RF instruction |
| kill_front | output | 1 | Cancel the instructions in IF and IS |
| kill_rf | output | 1 | Cancel the delay slot in RF |
| pc_sel | output | 2 | Next fetch address source: 0 sequential, 1 hold, 2 target |
| fwd_a | output | 3 | Forward source for the first operand |
| fwd_b | output | 3 | Forward source for the second operand |
| wb_we | output | 1 | Register write enable at WB |
| wb_dst | output | 5 | Register written at WB |

## Verification
On every cycle the assertions check several relations. A hold never leaves the fetch address sequential. A taken branch always selects the target. An annulled slot is never also held, and it leaves a non-writing record in EX. No load-use hold runs past two cycles. Other behaviours can only be shown by the bench's instruction sequences. These are the exact hold lengths for consumers one and two behind a load, the forward code chosen after a hold, the five-cycle path to writeback, and the absence of any write from a cancelled slot. The bench covers them with directed sequences and with a long random instruction stream compared against its own stage model.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_AW   = 5;   // register index width
    localparam int N_TRACK  = 5;   // tracked stages EX, DF, DS, TC, WB
    localparam int LOAD_WIN = 2;   // stages in which load data is not yet ready
    localparam int FWD_WIN  = 4;   // stages that can feed an operand

    typedef logic [REG_AW-1:0] reg_idx_t;

    typedef enum logic [2:0] {
        CLS_NOP   = 3'd0,
        CLS_ALU   = 3'd1,
        CLS_LOAD  = 3'd2,
        CLS_STORE = 3'd3,
        CLS_BR    = 3'd4,
        CLS_BRL   = 3'd5
    } op_cls_e;

    typedef enum logic [1:0] {
        PC_SEQ    = 2'd0,
        PC_HOLD   = 2'd1,
        PC_TARGET = 2'd2
    } pc_sel_e;

    typedef enum logic [2:0] {
        FWD_NONE = 3'd0,
        FWD_DF   = 3'd1,
        FWD_DS   = 3'd2,
        FWD_TC   = 3'd3,
        FWD_WB   = 3'd4
    } fwd_e;

    typedef struct packed {
        logic     valid;
        op_cls_e  cls;
        reg_idx_t dst;
        logic     we;
    } stage_rec_t;

    function automatic logic writes_reg(op_cls_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD);
    endfunction

    function automatic logic is_branch(op_cls_e c);
        return (c == CLS_BR) || (c == CLS_BRL);
    endfunction

    function automatic logic reads_dst(reg_idx_t src, reg_idx_t dst);
        return (src != '0) && (src == dst);
    endfunction

endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track
    import hz_pkg::*;
#(
    parameter int N = N_TRACK
) (
    input  logic                 clk,
    input  logic                 rst,
    input  stage_rec_t           entry,
    output stage_rec_t [N-1:0]   st
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st[0] <= entry;
            for (int i = 1; i < N; i++) begin
                st[i] <= st[i-1];
            end
        end
    end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
#(
    parameter int WIN = LOAD_WIN
) (
    input  logic                 rf_valid,
    input  reg_idx_t             src_a,
    input  reg_idx_t             src_b,
    input  stage_rec_t [WIN-1:0] st,
    output logic                 hit
);

    logic [WIN-1:0] per_stage;

    for (genvar i = 0; i < WIN; i++) begin : g_win
        assign per_stage[i] = st[i].valid && st[i].we && (st[i].cls == CLS_LOAD)
                            && (reads_dst(src_a, st[i].dst) || reads_dst(src_b, st[i].dst));
    end

    assign hit = rf_valid && (|per_stage);

endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
    import hz_pkg::*;
#(
    parameter int WIN = FWD_WIN
) (
    input  reg_idx_t             src,
    input  stage_rec_t [WIN-1:0] st,
    output fwd_e                 sel
);

    localparam int SW = $bits(fwd_e);

    // Scan from oldest to youngest so the nearest writer is the last one kept.
    always_comb begin
        sel = FWD_NONE;
        for (int i = WIN - 1; i >= 0; i--) begin
            if (st[i].valid && st[i].we && reads_dst(src, st[i].dst)) begin
                sel = fwd_e'(SW'(i + 1));
            end
        end
    end

endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl
    import hz_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stage_rec_t ex,
    input  logic       ex_taken,
    input  logic       rf_valid,
    input  logic       load_hit,
    output logic       redirect,
    output logic       annul,
    output logic       stall,
    output pc_sel_e    pc_sel
);

    logic br_in_ex;

    assign br_in_ex = ex.valid && is_branch(ex.cls);
    assign redirect = br_in_ex && ex_taken;
    assign annul    = rf_valid && br_in_ex && (ex.cls == CLS_BRL) && !ex_taken;
    assign stall    = load_hit && !annul;

    always_comb begin
        if (redirect)   pc_sel = PC_TARGET;
        else if (stall) pc_sel = PC_HOLD;
        else            pc_sel = PC_SEQ;
    end

    // R2: a held front end never fetches sequentially
    a_r2_hold_not_seq: assert property (@(posedge clk) disable iff (rst)
        stall |-> (pc_sel != PC_SEQ));

    // R6, R10: a taken branch always steers fetch to its target
    a_r6_taken_target: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (pc_sel == PC_TARGET));

    // R7: a cancelled slot is never held waiting for data
    a_r7_annul_no_hold: assert property (@(posedge clk) disable iff (rst)
        annul |-> !stall);

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hz_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rf_valid,
    input  logic [2:0]          rf_cls,
    input  logic [REG_AW-1:0]   rf_src_a,
    input  logic [REG_AW-1:0]   rf_src_b,
    input  logic [REG_AW-1:0]   rf_dst,
    input  logic                ex_taken,
    output logic                front_hold,
    output logic                ex_bubble,
    output logic                kill_front,
    output logic                kill_rf,
    output logic [1:0]          pc_sel,
    output logic [2:0]          fwd_a,
    output logic [2:0]          fwd_b,
    output logic                wb_we,
    output logic [REG_AW-1:0]   wb_dst
);

    localparam int WB_IDX = N_TRACK - 1;

    op_cls_e                  cls_in;
    stage_rec_t               entry;
    stage_rec_t [N_TRACK-1:0] st;
    logic                     load_hit, redirect, annul, stall;
    pc_sel_e                  pc_sel_e_w;
    fwd_e                     fa, fb;

    assign cls_in = op_cls_e'(rf_cls);

    hz_stage_track #(.N(N_TRACK)) u_track (
        .clk   (clk),
        .rst   (rst),
        .entry (entry),
        .st    (st)
    );

    hz_load_use #(.WIN(LOAD_WIN)) u_load_use (
        .rf_valid (rf_valid),
        .src_a    (rf_src_a),
        .src_b    (rf_src_b),
        .st       (st[LOAD_WIN-1:0]),
        .hit      (load_hit)
    );

    hz_branch_ctl u_branch (
        .clk      (clk),
        .rst      (rst),
        .ex       (st[0]),
        .ex_taken (ex_taken),
        .rf_valid (rf_valid),
        .load_hit (load_hit),
        .redirect (redirect),
        .annul    (annul),
        .stall    (stall),
        .pc_sel   (pc_sel_e_w)
    );

    hz_fwd_sel #(.WIN(FWD_WIN)) u_fwd_a (
        .src (rf_src_a),
        .st  (st[FWD_WIN-1:0]),
        .sel (fa)
    );

    hz_fwd_sel #(.WIN(FWD_WIN)) u_fwd_b (
        .src (rf_src_b),
        .st  (st[FWD_WIN-1:0]),
        .sel (fb)
    );

    // A held or cancelled RF instruction becomes an empty, non-writing record.
    always_comb begin
        entry.valid = rf_valid && !stall && !annul;
        entry.cls   = entry.valid ? cls_in : CLS_NOP;
        entry.dst   = rf_dst;
        entry.we    = entry.valid && writes_reg(cls_in);
    end

    assign front_hold = stall;
    assign ex_bubble  = stall || annul;
    assign kill_front = redirect;
    assign kill_rf    = annul;
    assign pc_sel     = pc_sel_e_w;
    assign fwd_a      = fa;
    assign fwd_b      = fb;
    assign wb_we      = st[WB_IDX].valid && st[WB_IDX].we;
    assign wb_dst     = wb_we ? st[WB_IDX].dst : '0;

    // R7: the cancelled slot lands in EX with no write enable
    a_r7_slot_nowrite: assert property (@(posedge clk) disable iff (rst)
        kill_rf |=> !st[0].we);

    // R3: a load-use hold never lasts beyond two cycles
    a_r3_hold_max_two: assert property (@(posedge clk) disable iff (rst)
        (front_hold && $past(front_hold)) |=> !front_hold);

endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
`timescale 1ns/1ps
module pipe_hazard_ctrl_bench;

    localparam int NOP = 0, ALU = 1, LD = 2, ST = 3, BR = 4, BRL = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rf_valid = 1'b0;
    logic [2:0] rf_cls = '0;
    logic [4:0] rf_src_a = '0, rf_src_b = '0, rf_dst = '0;
    logic       ex_taken = 1'b0;
    logic       front_hold, ex_bubble, kill_front, kill_rf, wb_we;
    logic [1:0] pc_sel;
    logic [2:0] fwd_a, fwd_b;
    logic [4:0] wb_dst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench-side stage model, index 0 = EX ... 4 = WB
    bit mv[5];
    int mc[5];
    int md[5];
    bit mw[5];
    bit mt[5];

    // observations of the most recent step
    int l_hold, l_bub, l_kf, l_kr, l_pc, l_fa, l_fb, l_we, l_dst;

    always #2.5 clk = ~clk;

    pipe_hazard_ctrl u_pipe_hazard_ctrl (
        .clk(clk), .rst(rst), .rf_valid(rf_valid), .rf_cls(rf_cls),
        .rf_src_a(rf_src_a), .rf_src_b(rf_src_b), .rf_dst(rf_dst),
        .ex_taken(ex_taken), .front_hold(front_hold), .ex_bubble(ex_bubble),
        .kill_front(kill_front), .kill_rf(kill_rf), .pc_sel(pc_sel),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .wb_we(wb_we), .wb_dst(wb_dst)
    );

    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit load_dep(int s, int i);
        return (s != 0) && mv[i] && mw[i] && (mc[i] == LD) && (md[i] == s);
    endfunction

    function automatic int exp_fwd(int s);
        if (s == 0) return 0;
        for (int i = 0; i < 4; i++)
            if (mv[i] && mw[i] && md[i] == s) return i + 1;
        return 0;
    endfunction

    task automatic step(input bit v, input int c, input int sa, input int sb,
                        input int d, input bit tk, output bit stalled);
        bit br_ex, taken, annul, hit, stall;
        @(negedge clk);
        rf_valid = v; rf_cls = 3'(c); rf_src_a = 5'(sa); rf_src_b = 5'(sb); rf_dst = 5'(d);
        br_ex    = mv[0] && (mc[0] == BR || mc[0] == BRL);
        ex_taken = br_ex ? mt[0] : 1'($urandom % 2);
        #1;
        taken = br_ex && ex_taken;
        annul = v && br_ex && (mc[0] == BRL) && !ex_taken;
        hit   = v && (load_dep(sa, 0) || load_dep(sb, 0) || load_dep(sa, 1) || load_dep(sb, 1));
        stall = hit && !annul;
        l_hold = front_hold; l_bub = ex_bubble; l_kf = kill_front; l_kr = kill_rf;
        l_pc = pc_sel; l_fa = fwd_a; l_fb = fwd_b; l_we = wb_we; l_dst = wb_dst;
        check("R2 hold", front_hold, stall);
        check("R2 bubble", ex_bubble, stall || annul);
        check("R6 kill_front", kill_front, taken);
        check("R7 kill_rf", kill_rf, annul);
        check("R10 pc_sel", pc_sel, taken ? 2 : (stall ? 1 : 0));
        check("R4 fwd_a", fwd_a, exp_fwd(sa));
        check("R4 fwd_b", fwd_b, exp_fwd(sb));
        check("R9 wb_we", wb_we, mv[4] && mw[4]);
        check("R9 wb_dst", wb_dst, (mv[4] && mw[4]) ? md[4] : 0);
        for (int i = 4; i > 0; i--) begin
            mv[i] = mv[i-1]; mc[i] = mc[i-1]; md[i] = md[i-1]; mw[i] = mw[i-1]; mt[i] = mt[i-1];
        end
        mv[0] = v && !stall && !annul;
        mc[0] = mv[0] ? c : NOP;
        md[0] = d;
        mw[0] = mv[0] && (c == ALU || c == LD);
        mt[0] = tk;
        stalled = stall;
    endtask

    task automatic issue(input int c, input int sa, input int sb, input int d,
                         input bit tk, output int nst);
        bit s;
        nst = 0;
        for (int k = 0; k < 8; k++) begin
            step(1'b1, c, sa, sb, d, tk, s);
            if (!s) break;
            nst++;
        end
    endtask

    task automatic drain();
        bit s;
        for (int k = 0; k < 6; k++) step(1'b0, NOP, 0, 0, 0, 1'b0, s);
    endtask

    initial begin
        bit s;
        int n;
        int seen;
        void'($urandom(32'd2024));
        for (int i = 0; i < 5; i++) begin
            mv[i] = 0; mc[i] = 0; md[i] = 0; mw[i] = 0; mt[i] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: idle state after reset
        step(1'b0, NOP, 0, 0, 0, 1'b0, s);
        check("R1 hold", l_hold, 0);
        check("R1 bubble", l_bub, 0);
        check("R1 kills", l_kf + l_kr, 0);
        check("R1 pc_sel", l_pc, 0);
        check("R1 wb_we", l_we, 0);
        check("R1 wb_dst", l_dst, 0);

        // R3: consumer directly behind a load waits two cycles
        issue(LD, 0, 0, 1, 1'b0, n);
        issue(ALU, 1, 0, 4, 1'b0, n);
        check("R3 one behind", n, 2);
        check("R5 fwd after hold", l_fa, 3);
        drain();
        // R3: consumer two behind waits one cycle
        issue(LD, 0, 0, 2, 1'b0, n);
        issue(ALU, 0, 0, 3, 1'b0, n);
        issue(ALU, 3, 2, 5, 1'b0, n);
        check("R3 two behind", n, 1);
        check("R5 fwd_b after hold", l_fb, 3);
        drain();
        // R3: register 0 creates no dependence
        issue(LD, 0, 0, 0, 1'b0, n);
        issue(ALU, 0, 0, 6, 1'b0, n);
        check("R3 r0 no hold", n, 0);
        drain();

        // R4: ALU result directly ahead is forwarded with no hold
        issue(ALU, 0, 0, 2, 1'b0, n);
        issue(ALU, 0, 2, 8, 1'b0, n);
        check("R4 no hold", n, 0);
        check("R4 fwd from DF", l_fb, 1);
        drain();

        // R6: taken branch kills IF/IS and selects target, slot survives
        issue(BR, 0, 0, 0, 1'b1, n);
        issue(ALU, 0, 0, 10, 1'b0, n);
        check("R6 kill_front", l_kf, 1);
        check("R6 pc target", l_pc, 2);
        check("R6 slot kept", l_kr, 0);
        drain();
        issue(BRL, 0, 0, 0, 1'b1, n);
        issue(ALU, 0, 0, 11, 1'b0, n);
        check("R6 likely taken", l_kf, 1);
        check("R6 likely slot kept", l_kr, 0);
        drain();

        // R8: plain branch not taken
        issue(BR, 0, 0, 0, 1'b0, n);
        issue(ALU, 0, 0, 12, 1'b0, n);
        check("R8 no kill_front", l_kf, 0);
        check("R8 no kill_rf", l_kr, 0);
        drain();

        // R7: branch-likely not taken cancels the slot; slot never writes
        issue(BRL, 0, 0, 0, 1'b0, n);
        issue(ALU, 0, 0, 7, 1'b0, n);
        check("R7 kill_rf", l_kr, 1);
        check("R7 bubble", l_bub, 1);
        seen = 0;
        for (int k = 0; k < 7; k++) begin
            step(1'b0, NOP, 0, 0, 0, 1'b0, s);
            if (l_we == 1 && l_dst == 7) seen++;
        end
        check("R7 no write of slot", seen, 0);

        // R9: ALU result reaches WB in the fifth following cycle
        issue(ALU, 0, 0, 9, 1'b0, n);
        for (int k = 1; k <= 5; k++) begin
            step(1'b0, NOP, 0, 0, 0, 1'b0, s);
            check("R9 wb timing", l_we, (k == 5) ? 1 : 0);
        end
        check("R9 wb dst", l_dst, 9);
        issue(ST, 0, 0, 9, 1'b0, n);
        seen = 0;
        for (int k = 0; k < 6; k++) begin
            step(1'b0, NOP, 0, 0, 0, 1'b0, s);
            seen += l_we;
        end
        check("R9 store no write", seen, 0);

        // R10: taken branch and load-use hold in the same cycle
        issue(LD, 0, 0, 1, 1'b0, n);
        issue(BR, 0, 0, 0, 1'b1, n);
        step(1'b1, ALU, 1, 0, 13, 1'b0, s);
        check("R10 hold", l_hold, 1);
        check("R10 target wins", l_pc, 2);
        issue(ALU, 1, 0, 13, 1'b0, n);
        drain();

        // constrained random stream
        begin
            bit held = 0;
            int c = 0, sa = 0, sb = 0, d = 0;
            bit tk = 0, v = 0;
            for (int k = 0; k < 4000; k++) begin
                if (!held) begin
                    v  = ($urandom % 8) != 0;
                    c  = $urandom % 6;
                    sa = $urandom % 4;
                    sb = $urandom % 4;
                    d  = $urandom % 4;
                    tk = 1'($urandom % 2);
                end
                step(v, c, sa, sb, d, tk, held);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule